// File: doc/BRIEF.md
# I2C SCL Clock Timing Generator

This block produces the SCL waveform for an I2C bus controller. A timing register holds a power-of-two prescaler exponent and two separately programmed phase lengths, one for SCL low and one for SCL high. Each phase length is counted in prescaled ticks and stored as one less than the number of ticks. One SCL period is therefore 2^E × ((L+1) + (H+1)) system clocks, where E is the exponent, L is the low field and H is the high field.

The block drives SCL open-drain. When `scl_oe` is 1 the pad pulls the line low. When it is 0 the line is released. The sensed bus level comes back on `scl_in`. The high phase counts only while SCL is actually sensed high, so a slave that stretches the clock holds the generator in the high phase.

A byte engine next to the block receives three single-cycle strobes: one at the start of each low phase, one at the start of each high phase, and one at the midpoint of the high phase for sampling SDA and checking arbitration. The clock fields and the other AC timing bits of the register are written through separate strobes, so rewriting the divider never disturbs the other timing values. All control and status pins are plain levels or strobes; no stream data crosses the block.

Top module: `scl_timing_gen`

## Requirements
- R1: With exponent E at register bits [3:0] and low field L, each low phase (`scl_oe`=1) lasts exactly (L+1)·2^E system clocks.
- R2: With high field H and SCL never held low by another device, each high phase (`scl_oe`=0 while enabled) lasts exactly (H+1)·2^E system clocks.
- R3: A `clk_we` write loads the exponent from wdata[3:0], the low field from wdata[15:12] and the high field from wdata[19:16]. `rdata` returns them at the same positions from the cycle after the write.
- R4: Only `ac_we` loads the AC timing bits wdata[31:20] into rdata[31:20]; a `clk_we` write alone leaves them unchanged. rdata[11:4] always read 0.
- R5: While the high phase is active and `scl_in` is sensed low, the high phase does not advance. Its length becomes the number of stretched clocks plus (H+1)·2^E.
- R6: While `enable` is 0, `scl_oe` is 0 from the next cycle and no strobe fires. After re-enable, the first low phase has its full programmed length.
- R7: `low_start` and `high_start` are one-cycle strobes in the first cycle of each low and high phase. The first `low_start` appears one cycle after `enable` is first sampled high.
- R8: `mid_high` fires once per high phase, floor((H+1)/2)·2^E sensed-high clocks after the phase begins, and only while SCL is released and sensed high.
- R9: With PHASE_W=3 (the narrow variant) only bits [14:12] and [18:16] are stored. Bits 15 and 19 read 0, and a phase lasts at most 8 ticks.
- R10: After reset `scl_oe`, all strobes and `rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the generator; 0 releases SCL and clears the counters |
| clk_we | input | 1 | Write strobe for the exponent and phase fields |
| ac_we | input | 1 | Write strobe for AC timing bits [31:20] |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Timing register readback |
| scl_in | input | 1 | Sensed SCL level |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| low_start | output | 1 | Strobe, first cycle of a low phase |
| high_start | output | 1 | Strobe, first cycle of a high phase |
| mid_high | output | 1 | Strobe, sampling point inside the high phase |

## Verification
Low and high durations are measured in system clocks for several (E, L, H) settings: all-zero fields, unequal phases, full 16-tick phases with a prescaler, and a large exponent with short phases. Together these separate exponent errors from off-by-one errors in either phase count, and show whether L and H have been swapped. The midpoint offset is checked for both odd and even tick counts, which exposes rounding errors. A stretched high phase, a disable in the middle of the low phase and the narrow variant check the hold path, the counter clear and the masking of the top field bits.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  localparam int EXP_W    = 4;
  localparam int FIELD_W  = 4;
  localparam int LOW_LSB  = 12;
  localparam int HIGH_LSB = 16;
  localparam int AC_LSB   = 20;
  localparam int AC_W     = 32 - AC_LSB;
  localparam int GAP_W    = LOW_LSB - EXP_W;
endpackage

// File: rtl/scl_timing_cfg.sv
module scl_timing_cfg
  import scl_timing_pkg::*;
#(
  parameter int PHASE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clk_we,
  input  logic               ac_we,
  input  logic [31:0]        wdata,
  output logic [EXP_W-1:0]   exp_o,
  output logic [PHASE_W-1:0] low_o,
  output logic [PHASE_W-1:0] high_o,
  output logic [31:0]        rdata
);
  logic [AC_W-1:0] ac_q;
  logic            unused_wdata;

  assign unused_wdata = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_o  <= '0;
      low_o  <= '0;
      high_o <= '0;
      ac_q   <= '0;
    end else begin
      if (clk_we) begin
        exp_o  <= wdata[EXP_W-1:0];
        low_o  <= wdata[LOW_LSB +: PHASE_W];
        high_o <= wdata[HIGH_LSB +: PHASE_W];
      end
      if (ac_we) begin
        ac_q <= wdata[AC_LSB +: AC_W];
      end
    end
  end

  generate
    if (PHASE_W == FIELD_W) begin : g_wide
      assign rdata = {ac_q, high_o, low_o, {GAP_W{1'b0}}, exp_o};
    end else begin : g_narrow
      localparam int PAD_W = FIELD_W - PHASE_W;
      assign rdata = {ac_q, {PAD_W{1'b0}}, high_o, {PAD_W{1'b0}}, low_o,
                      {GAP_W{1'b0}}, exp_o};
    end
  endgenerate
endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler
  import scl_timing_pkg::*;
#(
  parameter int E_W = EXP_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           advance,
  input  logic [E_W-1:0] exp_i,
  output logic           tick,
  output logic           at_zero
);
  localparam int PRE_W = (1 << E_W) - 1;

  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] limit;

  assign limit   = PRE_W'((32'd1 << exp_i) - 32'd1);
  assign tick    = advance && (pre_cnt == limit);
  assign at_zero = (pre_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
    end else if (!run) begin
      pre_cnt <= '0;
    end else if (advance) begin
      pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/scl_phase_ctl.sv
module scl_phase_ctl
  import scl_timing_pkg::*;
#(
  parameter int PHASE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               tick,
  input  logic               at_zero,
  input  logic               scl_in,
  input  logic [PHASE_W-1:0] low_cnt,
  input  logic [PHASE_W-1:0] high_cnt,
  output logic               advance,
  output logic               scl_oe,
  output logic               low_start,
  output logic               high_start,
  output logic               mid_high
);
  phase_e             state, prev;
  logic [PHASE_W-1:0] ph_cnt;
  logic [PHASE_W:0]   mid_pt;

  assign advance    = (state == PH_LOW) || ((state == PH_HIGH) && scl_in);
  assign scl_oe     = (state == PH_LOW);
  assign low_start  = (state == PH_LOW) && (prev != PH_LOW);
  assign high_start = (state == PH_HIGH) && (prev != PH_HIGH);
  assign mid_pt     = ({1'b0, high_cnt} + 1'b1) >> 1;
  assign mid_high   = (state == PH_HIGH) && scl_in && at_zero &&
                      ({1'b0, ph_cnt} == mid_pt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= PH_IDLE;
      prev   <= PH_IDLE;
      ph_cnt <= '0;
    end else begin
      prev <= state;
      if (!enable) begin
        state  <= PH_IDLE;
        ph_cnt <= '0;
      end else begin
        case (state)
          PH_IDLE: begin
            state  <= PH_LOW;
            ph_cnt <= '0;
          end
          PH_LOW: if (tick) begin
            if (ph_cnt >= low_cnt) begin
              state  <= PH_HIGH;
              ph_cnt <= '0;
            end else begin
              ph_cnt <= ph_cnt + 1'b1;
            end
          end
          PH_HIGH: if (tick) begin
            if (ph_cnt >= high_cnt) begin
              state  <= PH_LOW;
              ph_cnt <= '0;
            end else begin
              ph_cnt <= ph_cnt + 1'b1;
            end
          end
          default: begin
            state  <= PH_IDLE;
            ph_cnt <= '0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_timing_pkg::*;
#(
  parameter int PHASE_W = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        clk_we,
  input  logic        ac_we,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        scl_in,
  output logic        scl_oe,
  output logic        low_start,
  output logic        high_start,
  output logic        mid_high
);
  logic [EXP_W-1:0]   exp_f;
  logic [PHASE_W-1:0] low_f, high_f;
  logic               tick, at_zero, advance;

  scl_timing_cfg #(.PHASE_W(PHASE_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .clk_we(clk_we), .ac_we(ac_we),
    .wdata(wdata), .exp_o(exp_f), .low_o(low_f), .high_o(high_f),
    .rdata(rdata)
  );

  scl_prescaler #(.E_W(EXP_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(enable), .advance(advance),
    .exp_i(exp_f), .tick(tick), .at_zero(at_zero)
  );

  scl_phase_ctl #(.PHASE_W(PHASE_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
    .at_zero(at_zero), .scl_in(scl_in), .low_cnt(low_f),
    .high_cnt(high_f), .advance(advance), .scl_oe(scl_oe),
    .low_start(low_start), .high_start(high_start), .mid_high(mid_high)
  );
endmodule

// File: rtl/scl_timing_gen_chk.sv
module scl_timing_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        enable,
  input logic        clk_we,
  input logic        ac_we,
  input logic [31:0] wdata,
  input logic [31:0] rdata,
  input logic        scl_in,
  input logic        scl_oe,
  input logic        low_start,
  input logic        high_start,
  input logic        mid_high
);
  // R3: clock write lands in the exponent field on the next cycle
  a_r3_exp_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    clk_we |=> rdata[3:0] == $past(wdata[3:0]));

  // R4: AC bits survive a clock-only write
  a_r4_ac_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_we && !ac_we) |=> rdata[31:20] == $past(rdata[31:20]));

  // R4: gap bits stay zero
  a_r4_gap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[11:4] == 8'h00);

  // R5: a sensed-low line in the high phase keeps SCL released
  a_r5_stretch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && !scl_oe && !scl_in) |=> !scl_oe);

  // R6: disabling releases SCL
  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!scl_oe && !low_start && !high_start && !mid_high));

  // R7: each pull-low begins with a low_start strobe
  a_r7_low_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> low_start);

  // R7: each release while running begins with a high_start strobe
  a_r7_high_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_oe) && enable && $past(enable)) |-> high_start);

  // R8: the sample point lies in a released, sensed-high cycle
  a_r8_mid_valid: assert property (@(posedge clk) disable iff (!rst_n)
    mid_high |-> (!scl_oe && scl_in));
endmodule

bind scl_timing_gen scl_timing_gen_chk u_chk (.*);

// File: tb/test_scl_timing_gen.sv
`timescale 1ns/1ps
module test_scl_timing_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0, clk_we = 1'b0, ac_we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        scl_oe, low_start, high_start, mid_high, scl_in;
  logic        stretch = 1'b0;

  logic        enable_n = 1'b0, clk_we_n = 1'b0;
  logic [31:0] rdata_n;
  logic        oe_n, ls_n, hs_n, mh_n;

  int vectors = 0;
  int errors  = 0;

  always #10 clk = ~clk;

  assign scl_in = ~scl_oe & ~stretch;

  scl_timing_gen i_scl_timing_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .clk_we(clk_we),
    .ac_we(ac_we), .wdata(wdata), .rdata(rdata), .scl_in(scl_in),
    .scl_oe(scl_oe), .low_start(low_start), .high_start(high_start),
    .mid_high(mid_high)
  );

  scl_timing_gen #(.PHASE_W(3)) i_narrow (
    .clk(clk), .rst_n(rst_n), .enable(enable_n), .clk_we(clk_we_n),
    .ac_we(1'b0), .wdata(wdata), .rdata(rdata_n), .scl_in(~oe_n),
    .scl_oe(oe_n), .low_start(ls_n), .high_start(hs_n), .mid_high(mh_n)
  );

  task automatic check(input bit ok, input string tag, input longint act,
                       input longint exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit clkw, input bit acw, input logic [31:0] d);
    @(negedge clk);
    clk_we = clkw; ac_we = acw; wdata = d;
    @(negedge clk);
    clk_we = 1'b0; ac_we = 1'b0;
  endtask

  task automatic t_reset();
    check(scl_oe == 1'b0, "R10 scl_oe", scl_oe, 0);
    check({low_start, high_start, mid_high} == 3'b000, "R10 strobes",
          {low_start, high_start, mid_high}, 0);
    check(rdata == 32'h0, "R10 rdata", rdata, 0);
  endtask

  task automatic t_regs();
    wr(1'b0, 1'b1, 32'hABC0_0000);
    check(rdata == 32'hABC0_0000, "R4 ac write", rdata, 32'hABC0_0000);
    wr(1'b1, 1'b0, 32'hFFFF_FFFF);
    check(rdata == 32'hABCF_F00F, "R3 R4 clock write", rdata, 32'hABCF_F00F);
    wr(1'b1, 1'b0, 32'h0003_5002);
    check(rdata == 32'hABC3_5002, "R3 field positions", rdata, 32'hABC3_5002);
    wr(1'b0, 1'b1, 32'h1230_0000);
    check(rdata == 32'h1233_5002, "R4 ac only", rdata, 32'h1233_5002);
  endtask

  // Run one period and compare phase lengths against the formula
  task automatic t_period(input int e, input int l, input int h);
    int nlow, nhigh, mid;
    @(negedge clk); enable = 1'b0;
    wr(1'b1, 1'b0, (h << 16) | (l << 12) | e);
    enable = 1'b1;
    @(negedge clk);
    check(low_start && scl_oe, "R7 first low_start", {low_start, scl_oe}, 3);
    nlow = 0;
    while (scl_oe && nlow < 100000) begin nlow++; @(negedge clk); end
    check(high_start == 1'b1, "R7 high_start", high_start, 1);
    nhigh = 0; mid = -1;
    while (!scl_oe && nhigh < 100000) begin
      if (mid_high && mid < 0) mid = nhigh;
      nhigh++; @(negedge clk);
    end
    check(low_start == 1'b1, "R7 next low_start", low_start, 1);
    check(nlow == ((l + 1) << e), "R1 low length", nlow, (l + 1) << e);
    check(nhigh == ((h + 1) << e), "R2 high length", nhigh, (h + 1) << e);
    check(mid == (((h + 1) >> 1) << e), "R8 mid offset", mid,
          ((h + 1) >> 1) << e);
    enable = 1'b0;
  endtask

  task automatic t_stretch();
    int nhigh, mid;
    bit early;
    @(negedge clk); enable = 1'b0;
    wr(1'b1, 1'b0, 32'h0003_1001);
    enable = 1'b1;
    @(negedge clk);
    while (scl_oe) @(negedge clk);
    nhigh = 0; mid = -1; early = 1'b0;
    stretch = 1'b1;
    while (!scl_oe && nhigh < 1000) begin
      if (mid_high && mid < 0) mid = nhigh;
      if (nhigh < 10 && mid_high) early = 1'b1;
      nhigh++;
      @(negedge clk);
      if (nhigh == 10) stretch = 1'b0;
    end
    check(!early, "R5 no mid during stretch", early, 0);
    check(nhigh == 18, "R5 stretched high length", nhigh, 18);
    check(mid == 14, "R8 mid after stretch", mid, 14);
    enable = 1'b0;
  endtask

  task automatic t_disable();
    int nlow;
    bit any;
    @(negedge clk); enable = 1'b0;
    wr(1'b1, 1'b0, 32'h0000_3002);
    enable = 1'b1;
    repeat (6) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(scl_oe == 1'b0, "R6 released", scl_oe, 0);
    any = 1'b0;
    repeat (5) begin
      @(negedge clk);
      if (scl_oe || low_start || high_start || mid_high) any = 1'b1;
    end
    check(!any, "R6 quiet while disabled", any, 0);
    enable = 1'b1;
    @(negedge clk);
    nlow = 0;
    while (scl_oe && nlow < 1000) begin nlow++; @(negedge clk); end
    check(nlow == 16, "R6 full low after re-enable", nlow, 16);
    enable = 1'b0;
  endtask

  task automatic t_narrow();
    int nlow, nhigh;
    @(negedge clk); clk_we_n = 1'b1; wdata = 32'hFFFF_FFFF;
    @(negedge clk); clk_we_n = 1'b0;
    check(rdata_n == 32'h0007_700F, "R9 narrow readback", rdata_n,
          32'h0007_700F);
    @(negedge clk); clk_we_n = 1'b1; wdata = 32'h000F_F000;
    @(negedge clk); clk_we_n = 1'b0;
    enable_n = 1'b1;
    @(negedge clk);
    nlow = 0;
    while (oe_n && nlow < 1000) begin nlow++; @(negedge clk); end
    nhigh = 0;
    while (!oe_n && nhigh < 1000) begin nhigh++; @(negedge clk); end
    check(nlow == 8, "R9 narrow low", nlow, 8);
    check(nhigh == 8, "R9 narrow high", nhigh, 8);
    enable_n = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_period(0, 0, 0);
    t_period(0, 3, 5);
    t_period(2, 7, 2);
    t_period(4, 15, 15);
    t_period(10, 0, 1);
    t_stretch();
    t_disable();
    t_narrow();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule